// File: doc/BRIEF.md
# Serial Configuration Receiver with Holding Latch

This block is the device-side end of a three-wire configuration port made up of a serial clock, a data line and a strobe. A controller shifts a 24-bit configuration word in, most significant bit first. A rising strobe then moves the word into an active configuration register. That register drives the decoded field buses: reference divider, VCO divider, output divider select, secondary-clock function, duty-cycle bit and load-capacitance select. The three port lines are asynchronous to the block. They are synchronised to the system clock, and their edges are detected there, so no port line is ever used as a clock.

While the strobe is held high, the holding latch is transparent. Each serial clock edge then pushes the shifted word straight into the active register, so the fields change bit by bit. After reset the active register holds a default word that gives unity multiplication. An active-low power-down input controls an output-enable signal for the downstream clock drivers. A sticky flag reports when the active word carries a divider value that is not allowed.

Top module: `serial_cfg_rx`

## Requirements
- R1: On each synchronised rising edge of `sclk_i`, the 24-bit shift register moves up one place and takes `sdata_i` into bit 0, so the first bit sent ends up in bit 23.
- R2: A synchronised rising edge of `strobe_i` copies the whole shift register into the active configuration.
- R3: The active word decodes as follows: bits 23:22 are `cap_sel_o`, bit 21 is `duty_sel_o`, bits 20:19 are `clk2_sel_o`, bits 18:16 are `out_div_o`, bits 15:7 are `vco_div_o` and bits 6:0 are `ref_div_o`.
- R4: While `strobe_i` stays low, shifting does not change any field output, and `cfg_upd_o` stays low.
- R5: While `strobe_i` is high, every synchronised `sclk_i` rise loads the newly shifted word into the active configuration.
- R6: After reset the active word is 0x230406. This decodes to out_div 3, vco_div 8, ref_div 6, duty bit 1, clk2_sel 0 and cap_sel 0. `cfg_err_o` is low after reset.
- R7: `cfg_upd_o` is a single-cycle pulse, given once for each transfer into the active configuration. The active word never changes without it.
- R8: `cfg_err_o` is set by a transfer of a word whose vco_div is below 4 or whose ref_div is 0. It is cleared by the next transfer of a legal word, and it holds its value between transfers.
- R9: `clk_oe_o` follows `pd_ni` through the synchroniser. It goes low within three system clocks after `pd_ni` falls, and high again within three clocks after `pd_ni` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| strobe_i | input | 1 | Load strobe, asynchronous |
| pd_ni | input | 1 | Power-down, active low |
| ref_div_o | output | 7 | Reference divider word |
| vco_div_o | output | 9 | VCO divider word |
| out_div_o | output | 3 | Output divider select |
| clk2_sel_o | output | 2 | Secondary clock function |
| duty_sel_o | output | 1 | Duty-cycle setting |
| cap_sel_o | output | 2 | Crystal load-capacitance select |
| clk_oe_o | output | 1 | Clock output enable, low during power-down |
| cfg_err_o | output | 1 | Sticky illegal-divider flag |
| cfg_upd_o | output | 1 | One-cycle pulse on every transfer |

## Verification
The shift assertion assumes that `sdata_i` is stable for the synchroniser depth before and after each `sclk_i` rise. The stimulus meets this by holding the data bit for several system clocks on both sides of every serial edge. The assertions also assume that each serial clock and strobe level lasts at least two system clocks, so that no edge is lost in the synchroniser; the bench holds each level for three or more. Random words include some that are forced to carry small VCO words or a zero reference word, so that the error flag is both set and cleared.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned CFG_W   = 24;
  localparam int unsigned VDW_MIN = 4;

  typedef struct packed {
    logic [1:0] cap;
    logic       duty;
    logic [1:0] clk2;
    logic [2:0] odiv;
    logic [8:0] vdw;
    logic [6:0] rdw;
  } cfg_word_t;

  localparam logic [CFG_W-1:0] CFG_DEFAULT = 24'h230406;

  function automatic logic cfg_illegal(cfg_word_t w);
    return (w.vdw < 9'(VDW_MIN)) || (w.rdw == '0);
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] pipe_q [STAGES];
  logic [W-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= RST_VAL;
      else if (s == 0) pipe_q[s] <= async_i;
      else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else prev_q <= pipe_q[STAGES-1];
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int unsigned W = cfg_pkg::CFG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         data_i,
  output logic [W-1:0] sh_o,
  output logic [W-1:0] sh_next_o
);
  logic [W-1:0] sh_q;

  assign sh_next_o = {sh_q[W-2:0], data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else if (shift_i) sh_q <= sh_next_o;
  end

  assign sh_o = sh_q;

  assert_shift_in_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (sh_q[0] == $past(data_i)) && (sh_q[W-1:1] == $past(sh_q[W-2:0])));
endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
  import cfg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  cfg_word_t word_i,
  output cfg_word_t cfg_o,
  output logic      err_o,
  output logic      upd_o
);
  cfg_word_t cfg_q;
  logic      err_q, upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= cfg_word_t'(CFG_DEFAULT);
      err_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= load_i;
      if (load_i) begin
        cfg_q <= word_i;
        err_q <= cfg_illegal(word_i);
      end
    end
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;
  assign upd_o = upd_q;

  assert_no_silent_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q != $past(cfg_q)) |-> upd_q);
  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> !upd_q);
  assert_err_tracks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> (err_q == ((cfg_q.vdw < 9'(VDW_MIN)) || (cfg_q.rdw == 7'd0))));
  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_q |-> $stable(err_q));
endmodule

// File: rtl/serial_cfg_rx.sv
module serial_cfg_rx
  import cfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       sdata_i,
  input  logic       strobe_i,
  input  logic       pd_ni,
  output logic [6:0] ref_div_o,
  output logic [8:0] vco_div_o,
  output logic [2:0] out_div_o,
  output logic [1:0] clk2_sel_o,
  output logic       duty_sel_o,
  output logic [1:0] cap_sel_o,
  output logic       clk_oe_o,
  output logic       cfg_err_o,
  output logic       cfg_upd_o
);
  localparam int unsigned NSYNC = 4;
  // lane order: pd, strobe, sclk, data
  logic [NSYNC-1:0] lvl, rise;
  logic [CFG_W-1:0] sh, sh_next;
  logic             load;
  cfg_word_t        load_word, cfg;

  cfg_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({pd_ni, strobe_i, sclk_i, sdata_i}),
    .level_o (lvl),
    .rise_o  (rise)
  );

  cfg_shift #(.W(CFG_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (rise[1]),
    .data_i    (lvl[0]),
    .sh_o      (sh),
    .sh_next_o (sh_next)
  );

  // transparent while strobe is high: each shift also loads
  assign load      = rise[2] | (lvl[2] & rise[1]);
  assign load_word = cfg_word_t'(rise[1] ? sh_next : sh);

  cfg_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .word_i (load_word),
    .cfg_o  (cfg),
    .err_o  (cfg_err_o),
    .upd_o  (cfg_upd_o)
  );

  assign ref_div_o  = cfg.rdw;
  assign vco_div_o  = cfg.vdw;
  assign out_div_o  = cfg.odiv;
  assign clk2_sel_o = cfg.clk2;
  assign duty_sel_o = cfg.duty;
  assign cap_sel_o  = cfg.cap;
  assign clk_oe_o   = lvl[3];

  assert_quiet_without_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl[2] && !$past(lvl[2])) |=> !cfg_upd_o);
  assert_strobe_loads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise[2] |=> cfg_upd_o && (cfg == $past(load_word)));
endmodule

// File: tb/tb_serial_cfg_rx.sv
module tb_serial_cfg_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, strobe = 1'b0, pd_n = 1'b1;
  logic [6:0] ref_div; logic [8:0] vco_div; logic [2:0] out_div;
  logic [1:0] clk2_sel, cap_sel; logic duty_sel, clk_oe, cfg_err, cfg_upd;

  int n_chk = 0, n_fail = 0, upd_cnt = 0;
  logic [23:0] shadow = '0, active_exp = 24'h230406;
  logic err_exp = 1'b0;

  always #10 clk = ~clk;

  serial_cfg_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .strobe_i(strobe),
    .pd_ni(pd_n), .ref_div_o(ref_div), .vco_div_o(vco_div), .out_div_o(out_div),
    .clk2_sel_o(clk2_sel), .duty_sel_o(duty_sel), .cap_sel_o(cap_sel),
    .clk_oe_o(clk_oe), .cfg_err_o(cfg_err), .cfg_upd_o(cfg_upd));

  always @(negedge clk) if (cfg_upd) upd_cnt++;

  function automatic logic [23:0] pack_out();
    return {cap_sel, duty_sel, clk2_sel, out_div, vco_div, ref_div};
  endfunction

  function automatic logic illegal(logic [23:0] w);
    return (w[15:7] < 9'd4) || (w[6:0] == 7'd0);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    sdata = b; wait_clk(3);
    sclk = 1'b1; wait_clk(4);
    sclk = 1'b0; wait_clk(3);
    shadow = {shadow[22:0], b};
    if (strobe) begin
      active_exp = shadow;
      err_exp = illegal(shadow);
    end
  endtask

  task automatic send_word(logic [23:0] w);
    for (int i = 23; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1; wait_clk(4);
    strobe = 1'b0; wait_clk(5);
    active_exp = shadow;
    err_exp = illegal(shadow);
  endtask

  task automatic check_fields(string req);
    check(req, {8'h0, pack_out()}, {8'h0, active_exp});
    check({req, "_R8"}, {31'h0, cfg_err}, {31'h0, err_exp});
  endtask

  initial begin
    int base;
    logic [23:0] w;
    void'($urandom(32'd2917));
    wait_clk(3); rst_n = 1'b1; wait_clk(4);

    check("R6_word", {8'h0, pack_out()}, 32'h230406);
    check("R6_vco", {23'h0, vco_div}, 32'd8);
    check("R6_ref", {25'h0, ref_div}, 32'd6);
    check("R6_err", {31'h0, cfg_err}, 32'd0);
    check("R9_oe_idle", {31'h0, clk_oe}, 32'd1);

    // directed: known word, check field decode R3
    base = upd_cnt;
    send_word(24'h318A3B);
    check("R4_no_change", {8'h0, pack_out()}, 32'h230406);
    check("R4_no_upd", base, upd_cnt);
    pulse_strobe();
    check("R2_one_upd", upd_cnt - base, 32'd1);
    check("R3_vco", {23'h0, vco_div}, 32'd276);
    check("R3_ref", {25'h0, ref_div}, 32'd59);
    check("R3_odiv", {29'h0, out_div}, 32'd1);
    check("R3_clk2", {30'h0, clk2_sel}, 32'd2);
    check("R3_duty", {31'h0, duty_sel}, 32'd1);
    check("R3_cap", {30'h0, cap_sel}, 32'd0);

    // illegal then legal R8
    send_word(24'h000180); pulse_strobe();
    check_fields("R8_zero_ref");
    check("R8_set", {31'h0, cfg_err}, 32'd1);
    send_word(24'h000101); pulse_strobe();
    check("R8_low_vco", {31'h0, cfg_err}, 32'd1);
    send_word(24'h000201); pulse_strobe();
    check("R8_clear", {31'h0, cfg_err}, 32'd0);
    send_word(24'h000000);
    check("R8_sticky_no_load", {31'h0, cfg_err}, 32'd0);

    // random words, some forced illegal
    for (int k = 0; k < 24; k++) begin
      w = 24'($urandom());
      if (k % 5 == 1) w[15:7] = 9'($urandom_range(0, 3));
      if (k % 7 == 2) w[6:0] = 7'd0;
      base = upd_cnt;
      send_word(w);
      check("R4_rand_hold", {8'h0, pack_out()}, {8'h0, active_exp});
      pulse_strobe();
      check_fields("R2_R3_rand");
      check("R7_rand_pulse", upd_cnt - base, 32'd1);
    end

    // transparent mode R5
    w = 24'($urandom());
    base = upd_cnt;
    strobe = 1'b1; wait_clk(4);
    active_exp = shadow; err_exp = illegal(shadow);
    for (int i = 23; i >= 12; i--) send_bit(w[i]);
    check_fields("R5_mid");
    for (int i = 11; i >= 0; i--) send_bit(w[i]);
    check_fields("R5_end");
    check("R5_word", {8'h0, pack_out()}, {8'h0, w});
    check("R7_transparent_cnt", upd_cnt - base, 32'd25);
    strobe = 1'b0; wait_clk(4);

    // power-down R9
    pd_n = 1'b0; wait_clk(3);
    check("R9_oe_low", {31'h0, clk_oe}, 32'd0);
    check("R9_cfg_kept", {8'h0, pack_out()}, {8'h0, w});
    pd_n = 1'b1; wait_clk(3);
    check("R9_oe_high", {31'h0, clk_oe}, 32'd1);

    // reset returns default R6
    rst_n = 1'b0; wait_clk(2); rst_n = 1'b1; wait_clk(2);
    check("R6_after_reset", {8'h0, pack_out()}, 32'h230406);
    check("R6_err_after_reset", {31'h0, cfg_err}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_clk(150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule